// File: doc/BRIEF.md
# Flash Page-Read Completion Forecaster

This block runs alongside a flash channel command issuer and tells the host side, shortly before it happens, that a page read is about to finish. The issuer pulses a strobe at the moment a command leaves for the flash die. Timing starts at that strobe, so any time the request spent queued earlier is never counted. The block measures every command in clock cycles and learns from each finished small read. It keeps the three most recent small-read latencies and uses their truncated mean as the forecast for the next small read.

The host programs a lead window before operation. When a forecast small read is issued, the block arms a one-cycle notice, tagged with the command's tag, to fire that many cycles ahead of the forecast finish. The host can use this notice to be ready when the real completion arrives. Program and erase commands, other opcodes, transfers of 8192 bytes or more, and every command issued before three samples exist are flagged as not forecast. These commands produce no notice. Only one command is outstanding at a time. A completion strobe may share its cycle with the next issue strobe.

Top module: `rdlat_forecaster`

## Requirements
- R1: `lat_cyc` is 0 after reset. The cycle after an issue it reads 1, it rises by one every cycle after that, it sticks at 2^CNT_W-1 and does not wrap, and it keeps counting after a completion until the next issue.
- R2: A completion while a small read is outstanding records the value `lat_cyc` shows in that cycle as a sample. A completion with nothing outstanding, or for a command outside the small-read class, records nothing.
- R3: The forecast is floor((s1+s2+s3)/3) over the three newest samples. It is formed with a constant reciprocal multiply and is exact for every sum.
- R4: While fewer than three samples have been recorded since reset, every issue gives `no_fcst`=1 in the following cycle and arms no notice.
- R5: Only opcode 2'b00 (page read) can be forecast. Opcodes 2'b01 (program), 2'b10 (erase) and 2'b11 (other) give `no_fcst`=1, produce no notice and are not sampled.
- R6: A read with `iss_bytes` >= 8192 gives `no_fcst`=1, produces no notice and is not sampled. A read of 8191 bytes is still eligible.
- R7: For a forecast read with forecast P and window W, where P > W, `lead_vld` is high for exactly one cycle, the cycle in which `lat_cyc` equals P-W. In that cycle `lead_tag` equals the tag given at issue. A forecast read gives `no_fcst`=0.
- R8: When P <= W, the notice fires in the first cycle after the issue, when `lat_cyc` is 1.
- R9: A completion in a cycle before the notice cycle cancels the notice for good. A completion in the notice cycle itself still lets the notice show.
- R10: When a completion and a new issue share a cycle, the completion is sampled for the old command. The new command's forecast uses only the samples recorded before that cycle.
- R11: During and right after reset, `lead_vld`=0 and `no_fcst`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_vld | input | 1 | Command sent to the flash die this cycle |
| iss_op | input | 2 | Opcode: 00 read, 01 program, 10 erase, 11 other |
| iss_bytes | input | SZ_W | Transfer size in bytes |
| iss_tag | input | TAG_W | Tag returned with the notice |
| cmp_vld | input | 1 | Outstanding command finished this cycle |
| win_cyc | input | CNT_W | Lead window in cycles, static during operation |
| lead_vld | output | 1 | Early notice pulse |
| lead_tag | output | TAG_W | Tag of the command the notice belongs to |
| no_fcst | output | 1 | Last issued command is not forecast |
| lat_cyc | output | CNT_W | Cycles since the last issue, saturating |

## Verification
Two events can land in the same cycle: the lead notice and the real completion. The window and the measured latency are chosen so that P-W equals the latency, which places the completion exactly on the notice cycle. The scoreboard then expects the notice to appear with the correct tag and `lat_cyc` value. A second collision joins one command's completion with the next command's issue. There the scoreboard's forecast deliberately leaves out the sample that completes in that same cycle, and the following notice position shows whether the design did the same.

// File: rtl/rlf_pkg.sv
// Shared definitions for the read-latency forecaster.
// Assumes a 2-bit opcode field from the channel command issuer.
package rlf_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_MISC  = 2'b11
    } op_e;

    // Number of samples the forecast averages over; the reciprocal below is tied to it.
    localparam int HIST_DEPTH = 3;

endpackage

// File: rtl/rlf_lat_clock.sv
// Latency clock: counts cycles from the last issue strobe, saturating at the
// top of its range, and hands a sample to the averager when a completion
// ends an outstanding command of the sampled class.
// Assumes at most one command is outstanding; a new issue replaces the old one.
module rlf_lat_clock #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_cls,
    input  logic             stop,
    output logic [CNT_W-1:0] cnt,
    output logic             smp_vld,
    output logic [CNT_W-1:0] smp_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic busy_q;
    logic cls_q;

    // Count cycles since issue; reload on issue, hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            cls_q  <= 1'b0;
        end else if (start) begin
            cnt    <= CNT_W'(1);
            busy_q <= 1'b1;
            cls_q  <= start_cls;
        end else begin
            if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (stop) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Sample only completions that close an outstanding small read.
    always_comb begin
        smp_vld = stop && busy_q && cls_q;
        smp_val = cnt;
    end

    p_sat_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !start) |=> (cnt == CNT_MAX));

    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_idle_no_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !smp_vld);

endmodule

// File: rtl/rlf_avg3.sv
// Three-sample averager: keeps the newest samples in a shift history and
// forms floor(sum/3) with a constant reciprocal multiply, so no divider is used.
// The reciprocal carries CNT_W+4 fraction bits, which keeps the truncated
// result exact over the whole sum range.
module rlf_avg3 #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [CNT_W-1:0] smp_val,
    output logic [CNT_W-1:0] pred,
    output logic             trained
);
    import rlf_pkg::*;

    localparam int SUM_W = CNT_W + 2;
    localparam int FRAC_W = CNT_W + 4;
    localparam int PROD_W = SUM_W + FRAC_W;
    localparam longint unsigned RECIP_L = ((64'd1 << FRAC_W) + 64'd2) / 64'd3;
    localparam logic [FRAC_W-1:0] RECIP = RECIP_L[FRAC_W-1:0];
    localparam int NS_W = $clog2(HIST_DEPTH + 1);

    logic [HIST_DEPTH-1:0][CNT_W-1:0] hist_q;
    logic [NS_W-1:0]                  nsmp_q;
    logic [SUM_W-1:0]                 sum;
    logic [PROD_W-1:0]                prod;

    // Shift a new sample into the history; count samples up to the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            nsmp_q <= '0;
        end else if (smp_vld) begin
            for (int i = HIST_DEPTH - 1; i > 0; i--) begin
                hist_q[i] <= hist_q[i-1];
            end
            hist_q[0] <= smp_val;
            if (nsmp_q != NS_W'(HIST_DEPTH)) begin
                nsmp_q <= nsmp_q + NS_W'(1);
            end
        end
    end

    // Sum the history entries.
    always_comb begin
        sum = '0;
        for (int i = 0; i < HIST_DEPTH; i++) begin
            sum = sum + SUM_W'(hist_q[i]);
        end
    end

    // Divide by three through the reciprocal, truncating the fraction.
    always_comb begin
        prod    = PROD_W'(sum) * PROD_W'(RECIP);
        pred    = CNT_W'(prod >> FRAC_W);
        trained = (nsmp_q == NS_W'(HIST_DEPTH));
    end

    p_avg_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (SUM_W'(pred) * SUM_W'(3) <= sum) &&
        (sum - SUM_W'(pred) * SUM_W'(3) < SUM_W'(3)));

    p_trained_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trained |=> trained);

endmodule

// File: rtl/rlf_notice.sv
// Notice arming: at issue it decides whether the command is forecast,
// latches the tag and the cycle count at which the notice is due, and pulses
// the notice once when the latency clock reaches it. A completion before that
// cycle disarms it; a completion in that cycle lets it through.
// Assumes cnt reads 1 in the first cycle after issue.
module rlf_notice #(
    parameter int CNT_W = 20,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_go,
    input  logic             eligible,
    input  logic             trained,
    input  logic [CNT_W-1:0] pred,
    input  logic [CNT_W-1:0] win,
    input  logic [TAG_W-1:0] tag_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic             stop,
    output logic             lead_vld,
    output logic [TAG_W-1:0] lead_tag,
    output logic             no_fcst
);
    logic             armed_q;
    logic [CNT_W-1:0] due_q;
    logic [CNT_W-1:0] due_nxt;
    logic             fcst;

    // Work out the due count: window ahead of the forecast, no earlier than 1.
    always_comb begin
        fcst    = eligible && trained;
        due_nxt = (pred > win) ? (pred - win) : CNT_W'(1);
    end

    // Arm on issue, disarm on completion or once the notice has shown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            due_q    <= '0;
            lead_tag <= '0;
            no_fcst  <= 1'b1;
        end else if (iss_go) begin
            armed_q  <= fcst;
            due_q    <= due_nxt;
            lead_tag <= tag_in;
            no_fcst  <= !fcst;
        end else if (stop || lead_vld) begin
            armed_q <= 1'b0;
        end
    end

    // Pulse the notice in the due cycle.
    always_comb begin
        lead_vld = armed_q && (cnt == due_q);
    end

    p_quiet_unforecast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lead_vld |-> !no_fcst);

    p_inelig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && !eligible) |=> (no_fcst && !lead_vld));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_vld && !iss_go) |=> !lead_vld);

    p_near_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_go && fcst && pred <= win) |=> lead_vld);

    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !lead_vld && !iss_go) |=> !lead_vld);

endmodule

// File: rtl/rdlat_forecaster.sv
// Top of the read-latency forecaster: classifies each issued command, runs
// the latency clock, learns from small-read completions and raises a tagged
// early notice a programmable window ahead of the forecast finish.
// Assumes one outstanding command and a window held static while running.
module rdlat_forecaster #(
    parameter int CNT_W       = 20,
    parameter int TAG_W       = 4,
    parameter int SZ_W        = 16,
    parameter int SMALL_BYTES = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_vld,
    input  logic [1:0]       iss_op,
    input  logic [SZ_W-1:0]  iss_bytes,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             cmp_vld,
    input  logic [CNT_W-1:0] win_cyc,
    output logic             lead_vld,
    output logic [TAG_W-1:0] lead_tag,
    output logic             no_fcst,
    output logic [CNT_W-1:0] lat_cyc
);
    import rlf_pkg::*;

    logic             eligible;
    logic             smp_vld;
    logic [CNT_W-1:0] smp_val;
    logic [CNT_W-1:0] pred;
    logic             trained;

    // Small page reads are the only forecast class.
    always_comb begin
        eligible = (op_e'(iss_op) == OP_READ) && (iss_bytes < SZ_W'(SMALL_BYTES));
    end

    rlf_lat_clock #(.CNT_W(CNT_W)) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (iss_vld),
        .start_cls (eligible),
        .stop      (cmp_vld),
        .cnt       (lat_cyc),
        .smp_vld   (smp_vld),
        .smp_val   (smp_val)
    );

    rlf_avg3 #(.CNT_W(CNT_W)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_val (smp_val),
        .pred    (pred),
        .trained (trained)
    );

    rlf_notice #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_notice (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_go   (iss_vld),
        .eligible (eligible),
        .trained  (trained),
        .pred     (pred),
        .win      (win_cyc),
        .tag_in   (iss_tag),
        .cnt      (lat_cyc),
        .stop     (cmp_vld),
        .lead_vld (lead_vld),
        .lead_tag (lead_tag),
        .no_fcst  (no_fcst)
    );

    p_untrained_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !trained) |=> no_fcst);

    p_issue_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |=> (lat_cyc == CNT_W'(1)));

    p_nonread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && iss_op != 2'b00) |=> (no_fcst && !lead_vld));

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!lead_vld && no_fcst));

endmodule

// File: tb/test_rdlat_forecaster.sv
// Scoreboard bench: the driver task pushes each expected notice (tag and
// lat_cyc value) into a queue; the monitor pops and compares on every notice.
module test_rdlat_forecaster;

    localparam int CW = 12;
    localparam int TW = 4;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_vld = 1'b0;
    logic [1:0]    iss_op = 2'b00;
    logic [SW-1:0] iss_bytes = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          cmp_vld = 1'b0;
    logic [CW-1:0] win_cyc = '0;
    logic          lead_vld;
    logic [TW-1:0] lead_tag;
    logic          no_fcst;
    logic [CW-1:0] lat_cyc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct { int tag; int at; } exp_t;
    exp_t expq[$];
    int   samp[$];
    int   pend_val = 0;
    bit   pend_ok = 1'b0;

    always #10 clk = ~clk;

    rdlat_forecaster #(.CNT_W(CW), .TAG_W(TW), .SZ_W(SW), .SMALL_BYTES(8192)) i_rdlat_forecaster (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_op(iss_op),
        .iss_bytes(iss_bytes), .iss_tag(iss_tag), .cmp_vld(cmp_vld),
        .win_cyc(win_cyc), .lead_vld(lead_vld), .lead_tag(lead_tag),
        .no_fcst(no_fcst), .lat_cyc(lat_cyc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int fcst_now();
        int n = samp.size();
        return (samp[n-1] + samp[n-2] + samp[n-3]) / 3;
    endfunction

    // Monitor: every notice must match the head of the expectation queue (R3/R7).
    always @(negedge clk) begin
        if (rst_n && lead_vld) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R7 unexpected notice, lat_cyc", int'(lat_cyc), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(int'(lat_cyc) == e.at, "R3/R7 notice position", int'(lat_cyc), e.at);
                chk(int'(lead_tag) == e.tag, "R7 notice tag", int'(lead_tag), e.tag);
            end
        end
    end

    // Driver: issue one command at a negedge, complete it after lat cycles.
    task automatic go(input logic [1:0] op, input int bytes, input int tag,
                      input int lat, input bit chained, input bit leave_open);
        bit elig = (op == 2'b00) && (bytes < 8192);
        bit pr = elig && (samp.size() >= 3);
        int p = pr ? fcst_now() : 0;
        int fire = (p > int'(win_cyc)) ? p - int'(win_cyc) : 1;
        string req;
        iss_vld = 1'b1; iss_op = op; iss_bytes = SW'(bytes); iss_tag = TW'(tag);
        if (chained) cmp_vld = 1'b1;
        if (chained && pend_ok) samp.push_back(pend_val);  // R10: sampled after forecast
        pend_ok = 1'b0;
        if (pr && fire <= lat) expq.push_back('{tag, fire});
        @(negedge clk);
        iss_vld = 1'b0; cmp_vld = 1'b0;
        if (!elig) req = (op != 2'b00) ? "R5 no_fcst" : "R6 no_fcst";
        else if (!pr) req = "R4 no_fcst";
        else req = "R7 no_fcst";
        chk(no_fcst == !pr, req, int'(no_fcst), int'(!pr));
        chk(int'(lat_cyc) == 1, "R1 lat after issue", int'(lat_cyc), 1);
        repeat (lat - 1) @(negedge clk);
        if (leave_open) begin
            pend_val = lat; pend_ok = elig;
        end else begin
            cmp_vld = 1'b1;
            chk(int'(lat_cyc) == lat, "R2 lat at completion", int'(lat_cyc), lat);
            @(negedge clk);
            cmp_vld = 1'b0;
            if (elig) samp.push_back(lat);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!lead_vld, "R11 reset notice", int'(lead_vld), 0);
        chk(no_fcst, "R11 reset no_fcst", int'(no_fcst), 1);
        chk(lat_cyc == 0, "R1 reset lat", int'(lat_cyc), 0);
        rst_n = 1'b1;
        repeat (4200) @(negedge clk);
        chk(int'(lat_cyc) == 4095, "R1 saturation", int'(lat_cyc), 4095);
        win_cyc = CW'(10);
        // R4: training phase, all three unforecast.
        go(2'b00, 512, 1, 40, 0, 0);
        go(2'b00, 4096, 2, 50, 0, 0);
        go(2'b00, 2048, 3, 60, 0, 0);
        repeat (3) @(negedge clk);
        go(2'b00, 512, 4, 70, 0, 0);          // R7: forecast 50, due at 40
        go(2'b01, 512, 5, 30, 0, 0);          // R5 program
        go(2'b10, 0, 6, 20, 0, 0);            // R5 erase
        go(2'b11, 64, 7, 20, 0, 0);           // R5 other
        go(2'b00, 8192, 8, 25, 0, 0);         // R6 large read
        go(2'b00, 8191, 9, 61, 0, 0);         // R6 boundary, forecast 60
        chk(expq.size() == 0, "R7 notices consumed", expq.size(), 0);
        win_cyc = CW'(100);
        go(2'b00, 256, 10, 65, 0, 0);         // R3 forecast 63, R8 fires at 1
        chk(expq.size() == 0, "R8 near notice seen", expq.size(), 0);
        win_cyc = CW'(5);
        go(2'b00, 256, 11, 30, 0, 0);         // R9: due at 60, completes at 30
        repeat (80) @(negedge clk);
        chk(!lead_vld && expq.size() == 0, "R9 cancelled notice", expq.size(), 0);
        cmp_vld = 1'b1;                        // R2: stray completion, nothing outstanding
        @(negedge clk);
        cmp_vld = 1'b0;
        repeat (3) @(negedge clk);
        win_cyc = CW'(2);
        go(2'b00, 128, 12, 50, 0, 0);         // R9: forecast 52, due 50, same cycle as completion
        chk(expq.size() == 0, "R9 same-cycle notice", expq.size(), 0);
        go(2'b00, 128, 13, 44, 0, 1);         // R10: left open
        go(2'b00, 128, 14, 47, 1, 0);         // R10: chained issue
        go(2'b00, 128, 15, 60, 0, 0);
        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R10 chained notices", expq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule